// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block sits behind the bit-level receiver of an I2C slave. It looks at the bytes that follow a START or a repeated START and decides whether the transfer is meant for this device. Upstream logic captures each byte. It presents the byte with a one-cycle valid strobe, marks the first byte after a START, and pulses a STOP indicator. The block keeps registered flags that the ACK logic and the transfer engine downstream use: addressed, inside the address range, slave transmits, and general call. It also raises a one-cycle wake-up request on each match.

Several modes share one configuration. With 7-bit addressing, the device answers to its own address. It can also answer to a second address, or to an inclusive range of addresses between its own address and an upper bound. With 10-bit addressing, the first byte is a header and a second byte completes the address. The upper register then supplies the low seven bits of an optional second 10-bit address, and that address takes its top three bits from the device's own 10-bit address. The general-call byte can be accepted in either mode.

Top module: `i2c_slave_addr_match`

## Requirements
- R1: In 7-bit mode, a first byte whose bits [7:1] equal `cfg_own_addr[7:1]` sets `slv_addressed`, and `slv_tx` takes byte bit 0.
- R2: With `cfg_gcall_en` = 1, the first byte 0x00 sets `slv_addressed` and `gcall_hit` and clears `slv_tx`. With `cfg_gcall_en` = 0 it does not match, unless another rule matches it. The byte 0x01 is never a general call.
- R3: With `cfg_range_en` = 0 and `cfg_upper_addr[7:1]` nonzero, a first byte whose bits [7:1] equal `cfg_upper_addr[7:1]` matches like the own address.
- R4: With `cfg_range_en` = 1, a first byte whose bits [7:1] lie between `cfg_own_addr[7:1]` and `cfg_upper_addr[7:1]`, both ends included, matches and sets `range_hit`.
- R5: An upper address of zero gives no second address and no range.
- R6: While `cfg_range_en` = 1, an upper address at or below the own address makes the range inactive. Only the own address then matches, and the upper value is not used as a second address.
- R7: In 10-bit mode (`cfg_addr10_en` = 1), the first byte must be `11110` followed by `cfg_own_addr[10:9]` and then write (bit 0 = 0). The following non-first byte must equal `cfg_own_addr[8:1]`. This match sets `slv_addressed` with `slv_tx` = 0. The header alone leaves the flags clear.
- R8: In 10-bit mode with a nonzero upper address, a second byte equal to `{cfg_own_addr[8], cfg_upper_addr[7:1]}` after a valid header also matches.
- R9: In 10-bit mode, while the device is still addressed, a repeated-START header with the read bit set matches without a second byte and sets `slv_tx`. The same header matches nothing when the device is not addressed.
- R10: Reset clears every flag. `stop_det` clears every flag and any pending header. A first byte that does not match clears every flag.
- R11: Each match raises `wake_req` for exactly the one cycle that follows the capturing edge when `cfg_wake_en` = 1. It never rises when `cfg_wake_en` = 0.
- R12: A non-first byte that does not complete a pending 10-bit header leaves all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| byte_vld | input | 1 | One-cycle strobe for a received byte |
| byte_data | input | 8 | Received byte |
| first_byte | input | 1 | The byte is the first after a START or repeated START |
| stop_det | input | 1 | STOP seen on the bus; takes priority over a byte in the same cycle |
| cfg_addr10_en | input | 1 | Selects 10-bit addressing |
| cfg_own_addr | input | 11 | Own address: 7-bit in [7:1], 10-bit in [10:1], bit 0 zero |
| cfg_upper_addr | input | 8 | Upper address in [7:1]; zero disables it |
| cfg_range_en | input | 1 | Treats the upper address as a range bound |
| cfg_gcall_en | input | 1 | Accepts the general-call byte |
| cfg_wake_en | input | 1 | Allows wake-up requests |
| slv_addressed | output | 1 | The device is addressed |
| range_hit | output | 1 | The match came from the address range |
| slv_tx | output | 1 | The slave transmits (read transfer) |
| gcall_hit | output | 1 | The match was a general call |
| wake_req | output | 1 | One-cycle wake-up request on a match |

## Verification
The bench sends every first-byte value under several 7-bit configurations and compares each result with an arithmetic model. The configurations include a second address, a range, a zero upper address and an upper address below the own address. A design with an off-by-one range bound would miss the own or the upper endpoint. A design that lets a bad upper value stay active would accept addresses below the own address. For 10-bit mode, the bench sends every possible second byte after a valid header. It then tries read headers with and without a prior match, a wrong header, and a STOP in the middle of a transfer. These catch a design that matches on the header alone, or that lets a read header match without earlier addressing. Data bytes after a match catch a design that re-decodes payload as an address.

// File: rtl/i2c_slave_addr_match.sv
module i2c_slave_addr_match (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        byte_vld,
  input  logic [7:0]  byte_data,
  input  logic        first_byte,
  input  logic        stop_det,
  input  logic        cfg_addr10_en,
  input  logic [10:0] cfg_own_addr,
  input  logic [7:0]  cfg_upper_addr,
  input  logic        cfg_range_en,
  input  logic        cfg_gcall_en,
  input  logic        cfg_wake_en,
  output logic        slv_addressed,
  output logic        range_hit,
  output logic        slv_tx,
  output logic        gcall_hit,
  output logic        wake_req
);

  logic [6:0] a7, own7, up7;
  logic [9:0] own10;
  logic       rw, up_on, rng_on, in_rng, gc_m, m7, hdr, lo_m;
  logic       hdr_pend;
  logic       n_addr, n_rng, n_tx, n_gc, n_pend, n_evt, upd;

  assign a7     = byte_data[7:1];
  assign rw     = byte_data[0];
  assign own7   = cfg_own_addr[7:1];
  assign own10  = cfg_own_addr[10:1];
  assign up7    = cfg_upper_addr[7:1];
  assign up_on  = |up7;
  assign rng_on = cfg_range_en && up_on && (up7 > own7);
  assign in_rng = rng_on && (a7 >= own7) && (a7 <= up7);
  assign gc_m   = cfg_gcall_en && (byte_data == 8'h00);
  assign m7     = (a7 == own7) || in_rng || (!cfg_range_en && up_on && (a7 == up7));
  assign hdr    = (byte_data[7:3] == 5'b11110) && (byte_data[2:1] == own10[9:8]);
  assign lo_m   = (byte_data == own10[7:0]) || (up_on && (byte_data == {own10[7], up7}));

  always_comb begin
    upd    = 1'b0;
    n_addr = 1'b0;
    n_rng  = 1'b0;
    n_tx   = 1'b0;
    n_gc   = 1'b0;
    n_pend = 1'b0;
    n_evt  = 1'b0;
    if (byte_vld && first_byte) begin
      upd = 1'b1;
      if (gc_m) begin
        n_addr = 1'b1;
        n_gc   = 1'b1;
      end else if (!cfg_addr10_en) begin
        n_addr = m7;
        n_rng  = m7 && in_rng;
        n_tx   = m7 && rw;
      end else if (hdr && !rw) begin
        n_pend = 1'b1;
      end else if (hdr && rw && slv_addressed && !gcall_hit) begin
        n_addr = 1'b1;
        n_tx   = 1'b1;
      end
      n_evt = n_addr;
    end else if (byte_vld && hdr_pend) begin
      upd    = 1'b1;
      n_addr = lo_m;
      n_evt  = lo_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slv_addressed <= 1'b0;
      range_hit     <= 1'b0;
      slv_tx        <= 1'b0;
      gcall_hit     <= 1'b0;
      hdr_pend      <= 1'b0;
      wake_req      <= 1'b0;
    end else begin
      wake_req <= 1'b0;
      if (stop_det) begin
        slv_addressed <= 1'b0;
        range_hit     <= 1'b0;
        slv_tx        <= 1'b0;
        gcall_hit     <= 1'b0;
        hdr_pend      <= 1'b0;
      end else if (upd) begin
        slv_addressed <= n_addr;
        range_hit     <= n_rng;
        slv_tx        <= n_tx;
        gcall_hit     <= n_gc;
        hdr_pend      <= n_pend;
        wake_req      <= n_evt && cfg_wake_en;
      end
    end
  end

endmodule

module i2c_slave_addr_match_chk (
  input logic clk,
  input logic rst_n,
  input logic byte_vld,
  input logic first_byte,
  input logic stop_det,
  input logic hdr_pend,
  input logic slv_addressed,
  input logic range_hit,
  input logic slv_tx,
  input logic gcall_hit,
  input logic wake_req
);

  AST_GCALL_RX_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    gcall_hit |-> (slv_addressed && !slv_tx)); // R2

  AST_RANGE_NEEDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    range_hit |-> (slv_addressed && !gcall_hit)); // R4

  AST_PEND_NOT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_pend |-> !slv_addressed); // R7

  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!slv_addressed && !range_hit && !gcall_hit && !hdr_pend)); // R10

  AST_WAKE_FROM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> (slv_addressed && $past(byte_vld))); // R11

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && !first_byte && !stop_det && !hdr_pend) |=>
      ($stable(slv_addressed) && $stable(slv_tx) && $stable(range_hit))); // R12

endmodule

bind i2c_slave_addr_match i2c_slave_addr_match_chk u_chk (.*);

// File: tb/i2c_slave_addr_match_tb.sv
`timescale 1ns/1ps
module i2c_slave_addr_match_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_vld = 1'b0;
  logic [7:0]  byte_data = '0;
  logic        first_byte = 1'b0;
  logic        stop_det = 1'b0;
  logic        cfg_addr10_en = 1'b0;
  logic [10:0] cfg_own_addr = '0;
  logic [7:0]  cfg_upper_addr = '0;
  logic        cfg_range_en = 1'b0;
  logic        cfg_gcall_en = 1'b0;
  logic        cfg_wake_en = 1'b0;
  logic        slv_addressed, range_hit, slv_tx, gcall_hit, wake_req;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  i2c_slave_addr_match u_dut (.*);

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b, input logic f);
    @(negedge clk);
    byte_data = b; first_byte = f; byte_vld = 1'b1;
    @(negedge clk);
    byte_vld = 1'b0; first_byte = 1'b0;
  endtask

  task automatic stop_pulse();
    @(negedge clk);
    stop_det = 1'b1;
    @(negedge clk);
    stop_det = 1'b0;
  endtask

  task automatic chk_all(input string tag, input logic ea, input logic er,
                         input logic et, input logic eg);
    chk({tag, " addressed"}, slv_addressed, ea);
    chk({tag, " range"}, range_hit, er);
    chk({tag, " tx"}, slv_tx, et);
    chk({tag, " gcall"}, gcall_hit, eg);
  endtask

  task automatic sweep7(input string tag, input logic [6:0] p, input logic [6:0] u,
                        input logic ren, input logic gcen, input logic wen);
    cfg_addr10_en = 1'b0; cfg_own_addr = {3'b0, p, 1'b0};
    cfg_upper_addr = {u, 1'b0}; cfg_range_en = ren; cfg_gcall_en = gcen;
    cfg_wake_en = wen;
    for (int b = 0; b < 256; b++) begin
      logic [6:0] a;
      logic ea, er, et, eg;
      a = b[7:1];
      er = 0; eg = 0;
      if (gcen && b == 0) begin
        ea = 1; et = 0; eg = 1;
      end else begin
        er = ren && (u != 0) && (u > p) && (a >= p) && (a <= u);
        ea = (a == p) || er || (!ren && (u != 0) && (a == u));
        et = ea && b[0];
      end
      put(b[7:0], 1'b1);
      chk_all(tag, ea, er, et, eg);
      chk({tag, " R11 wake"}, wake_req, wen && ea);
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_all("R10 reset", 0, 0, 0, 0);
    chk("R10 reset wake", wake_req, 0);
    rst_n = 1'b1;

    sweep7("R1 R3 second address", 7'h25, 7'h30, 0, 1, 1);
    sweep7("R4 range", 7'h25, 7'h30, 1, 0, 0);
    sweep7("R5 zero upper", 7'h25, 7'h00, 1, 1, 1);
    sweep7("R5 zero upper norange", 7'h25, 7'h00, 0, 0, 1);
    sweep7("R6 upper below own", 7'h25, 7'h20, 1, 1, 0);
    sweep7("R6 upper equal own", 7'h25, 7'h25, 1, 0, 1);
    sweep7("R2 gcall", 7'h01, 7'h7F, 1, 1, 1);

    // wake lasts one cycle
    put(8'h4B, 1'b1);
    chk("R11 wake pulse", wake_req, 1);
    @(negedge clk);
    chk("R11 wake drops", wake_req, 0);

    // data bytes after a match leave flags alone
    cfg_own_addr = {3'b0, 7'h25, 1'b0}; cfg_range_en = 0; cfg_upper_addr = 0;
    put(8'h4B, 1'b1);
    for (int i = 0; i < 4; i++) begin
      put(8'h00 + 8'(i * 37), 1'b0);
      chk_all("R12 data hold", 1, 0, 1, 0);
      chk("R12 data wake", wake_req, 0);
    end
    stop_pulse();
    chk_all("R10 stop", 0, 0, 0, 0);
    put(8'h4A, 1'b1);
    put(8'h10, 1'b1);
    chk_all("R10 failed start", 0, 0, 0, 0);

    // 10-bit: own 0x2B5, upper 0x1A -> second 0x29A
    cfg_addr10_en = 1; cfg_own_addr = {10'h2B5, 1'b0}; cfg_upper_addr = {7'h1A, 1'b0};
    cfg_range_en = 1; cfg_gcall_en = 0; cfg_wake_en = 1;
    for (int b = 0; b < 256; b++) begin
      logic e;
      e = (b == 8'hB5) || (b == 8'h9A);
      put(8'hF4, 1'b1);
      chk_all("R7 header only", 0, 0, 0, 0);
      put(b[7:0], 1'b0);
      chk_all("R7 R8 second byte", e, 0, 0, 0);
      chk("R11 wake 10b", wake_req, e);
    end
    put(8'hF4, 1'b1);
    put(8'hB5, 1'b0);
    put(8'hF5, 1'b1);
    chk_all("R9 read rematch", 1, 0, 1, 0);
    stop_pulse();
    chk_all("R10 stop 10b", 0, 0, 0, 0);
    put(8'hF5, 1'b1);
    chk_all("R9 read without match", 0, 0, 0, 0);
    put(8'hF6, 1'b1);
    put(8'hB5, 1'b0);
    chk_all("R7 wrong header", 0, 0, 0, 0);
    cfg_upper_addr = 0;
    put(8'hF4, 1'b1);
    put(8'h9A, 1'b0);
    chk_all("R5 zero upper 10b", 0, 0, 0, 0);
    put(8'hF4, 1'b1);
    stop_pulse();
    put(8'hB5, 1'b0);
    chk_all("R10 stop drops header", 0, 0, 0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule